// File: doc/BRIEF.md
# Dual-Channel Timer Input Capture

This block is a 16-bit free-running timer counter with two input-capture channels, reached through a small 8-bit register bus. Each channel watches its own capture pin. On the edge that its control bit selects, the channel copies the counter into a read-only 16-bit capture register and raises its capture flag. Software reads that register as a high byte and a low byte. A single interrupt line is raised while any flag is set, provided the shared capture-interrupt enable is on and the global mask is off.

The counter is clocked by a prescaled tick. The tick is the core clock divided by 2, 4 or 8, or an external tick-enable input. Software reads the high byte first. That read freezes the channel's capture register until the low byte is read, so the two halves always belong to the same capture. A flag is cleared by a two-step handshake: read the status register while the flag is set, then read or write that channel's low byte. When the timer runs a pulse-generation mode (PWM or one-pulse), channel 1 ignores its pin and only channel 2 captures.

Top module: `cap_timer`

Register addresses on `addr_i`: 0 control, 1 status, 2/3 channel-1 capture high/low, 4/5 channel-2 capture high/low, 6/7 counter high/low.

## Requirements
- R1: After reset the control register reads 0x08 (global mask set, all else 0). Status, both capture registers and the counter read 0, and `irq_o` is low.
- R2: Control bits [5:4] pick the counter tick. With 00 the counter advances once per 4 clocks, with 01 once per 2 and with 10 once per 8. With 11 it advances once per clock in which `ext_tick_i` is high and holds otherwise. Addresses 6/7 return the counter high/low byte with no side effect.
- R3: Control bit 0 (channel 1) and bit 1 (channel 2) select the active edge: 1 for rising, 0 for falling. A transition in the other direction captures nothing and sets no flag.
- R4: On an active edge the channel latches the counter value into its capture register, readable at addresses 2/3 or 4/5. The value is held until the next capture, and status bit 0 (channel 1) or bit 1 (channel 2) is set.
- R5: `irq_o` is high exactly while some capture flag is set, control bit 2 (interrupt enable) is 1 and control bit 3 (global mask) is 0. A flag set while the interrupt is gated stays pending and raises `irq_o` once the gate opens.
- R6: A flag clears only on a low-byte read or write of its channel that follows a status read made while the flag was set. A low-byte access alone leaves it set. If a capture lands in the same cycle as the clearing access, the flag stays set and a new status read is needed.
- R7: Reading a channel's high byte blocks captures and flag setting on that channel until its low byte is read. Edges that arrive while blocked are discarded, not replayed.
- R8: While control bit 6 (PWM mode) or bit 7 (one-pulse mode) is set, channel 1 ignores its pin. Channel 2 is unaffected.
- R9: A pin transition applied before clock edge k is captured at clock edge k+2. The flag is not yet visible after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 3 | Register address |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wr_i | input | 1 | Write strobe, one cycle per access |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| cap_pin_i | input | 2 | Capture pins, bit 0 for channel 1 |
| ext_tick_i | input | 1 | External counter tick enable (clock select 11) |
| irq_o | output | 1 | Shared capture interrupt |

## Verification
The bench lines up a capture on channel 2 with the low-byte read that would clear its already armed flag, so both land on the same clock edge. It does this by placing the pin transition exactly two cycles before the read strobe. It then judges the outcome through the status bit, which must still be set, and through the capture register, which must hold the counter value frozen at that moment. The counter is frozen through the external tick so that every captured value is known in advance. Random counter values and edge polarities cover the ordinary capture path. Directed cases cover the lock window, the pulse modes and the one-cycle latency boundary.

// File: rtl/cap_tmr_pkg.sv
package cap_tmr_pkg;

  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT   = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_CNT_HI = 3'd6;
  localparam logic [ADDR_W-1:0] ADDR_CNT_LO = 3'd7;

  // counter tick source encoding
  typedef enum logic [1:0] {
    TICK_DIV4 = 2'b00,
    TICK_DIV2 = 2'b01,
    TICK_DIV8 = 2'b10,
    TICK_EXT  = 2'b11
  } tick_sel_e;

  typedef struct packed {
    logic       one_pulse;  // bit 7
    logic       pwm;        // bit 6
    tick_sel_e  tick_sel;   // bits 5:4
    logic       gmask;      // bit 3
    logic       ien;        // bit 2
    logic [1:0] rise;       // bits 1:0, per channel
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{one_pulse: 1'b0, pwm: 1'b0, tick_sel: TICK_DIV4,
                                 gmask: 1'b1, ien: 1'b0, rise: 2'b00};

  function automatic logic [ADDR_W-1:0] cap_hi_addr(input int unsigned ch);
    return ADDR_W'(2 + 2 * ch);
  endfunction

  function automatic logic [ADDR_W-1:0] cap_lo_addr(input int unsigned ch);
    return ADDR_W'(3 + 2 * ch);
  endfunction

endpackage

// File: rtl/cap_tmr_tick.sv
module cap_tmr_tick
  import cap_tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PRE_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  tick_sel_e        tick_sel_i,
  input  logic             ext_tick_i,
  output logic [CNT_W-1:0] cnt_o
);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tick;

  always_comb begin
    pre_d = pre_q + PRE_W'(1);
    unique case (tick_sel_i)
      TICK_DIV2: tick = &pre_q[0:0];
      TICK_DIV4: tick = &pre_q[1:0];
      TICK_DIV8: tick = &pre_q[2:0];
      default:   tick = ext_tick_i;
    endcase
    cnt_d = cnt_q;
    if (tick) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= pre_d;
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/cap_tmr_edge.sv
module cap_tmr_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic rise_i,
  output logic edge_o
);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q;
  logic                   smp;

  assign smp = sync_q[SYNC_STAGES-1];

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], pin_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= smp;
    end
  end

  assign edge_o = rise_i ? (smp & ~prev_q) : (~smp & prev_q);

endmodule

// File: rtl/cap_tmr_chan.sv
module cap_tmr_chan #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             edge_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             stat_rd_i,
  input  logic             hi_rd_i,
  input  logic             lo_rd_i,
  input  logic             lo_acc_i,
  output logic [CNT_W-1:0] cap_o,
  output logic             flag_o,
  output logic             lock_o
);

  logic [CNT_W-1:0] cap_q, cap_d;
  logic             flag_q, flag_d;
  logic             lock_q, lock_d;
  logic             arm_q, arm_d;
  logic             blocked, take;

  // a high-byte read blocks in its own cycle; the low-byte read cycle is free
  assign blocked = hi_rd_i | (lock_q & ~lo_rd_i);
  assign take    = edge_i & en_i & ~blocked;

  always_comb begin
    cap_d  = cap_q;
    flag_d = flag_q;
    arm_d  = arm_q;
    lock_d = lock_q;
    if (take) begin
      cap_d  = cnt_i;
      flag_d = 1'b1;
      arm_d  = 1'b0;
    end else if (lo_acc_i && arm_q) begin
      flag_d = 1'b0;
      arm_d  = 1'b0;
    end else if (stat_rd_i && flag_q) begin
      arm_d  = 1'b1;
    end
    if (hi_rd_i) begin
      lock_d = 1'b1;
    end else if (lo_rd_i) begin
      lock_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q  <= '0;
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      cap_q  <= cap_d;
      flag_q <= flag_d;
      arm_q  <= arm_d;
      lock_q <= lock_d;
    end
  end

  assign cap_o  = cap_q;
  assign flag_o = flag_q;
  assign lock_o = lock_q;

endmodule

// File: rtl/cap_timer.sv
module cap_timer
  import cap_tmr_pkg::*;
#(
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PRE_W       = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic [1:0]        cap_pin_i,
  input  logic              ext_tick_i,
  output logic              irq_o
);

  localparam int unsigned CNT_W  = 2 * BYTE_W;
  localparam int unsigned NUM_CH = 2;
  localparam int unsigned RST_W  = 2;

  // reset: asserted asynchronously, released on the clock
  logic [RST_W-1:0] rst_sync_q;
  logic             rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[RST_W-2:0], 1'b1};
    end
  end
  assign rst_n = rst_sync_q[RST_W-1];

  // control register
  ctrl_t ctrl_q, ctrl_d;
  logic  ctrl_we;

  assign ctrl_we = wr_i && (addr_i == ADDR_CTRL);

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_we) begin
      ctrl_d = ctrl_t'(wdata_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
    end else begin
      ctrl_q <= ctrl_d;
    end
  end

  // counter
  logic [CNT_W-1:0] cnt_w;

  cap_tmr_tick #(
    .CNT_W (CNT_W),
    .PRE_W (PRE_W)
  ) tick_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .tick_sel_i (ctrl_q.tick_sel),
    .ext_tick_i (ext_tick_i),
    .cnt_o      (cnt_w)
  );

  // channels
  logic                            stat_rd;
  logic [NUM_CH-1:0]               edge_w, en_w, flag_w, lock_w;
  logic [NUM_CH-1:0]               hi_rd_w, lo_rd_w, lo_acc_w;
  logic [NUM_CH-1:0][CNT_W-1:0]    cap_w;

  assign stat_rd = rd_i && (addr_i == ADDR_STAT);

  // channel 1 (index 0) is taken by the pulse modes
  assign en_w[0] = ~(ctrl_q.pwm | ctrl_q.one_pulse);
  assign en_w[1] = 1'b1;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    assign hi_rd_w[ch]  = rd_i && (addr_i == cap_hi_addr(ch));
    assign lo_rd_w[ch]  = rd_i && (addr_i == cap_lo_addr(ch));
    assign lo_acc_w[ch] = (rd_i || wr_i) && (addr_i == cap_lo_addr(ch));

    cap_tmr_edge #(
      .SYNC_STAGES (SYNC_STAGES)
    ) edge_i (
      .clk_i  (clk_i),
      .rst_ni (rst_n),
      .pin_i  (cap_pin_i[ch]),
      .rise_i (ctrl_q.rise[ch]),
      .edge_o (edge_w[ch])
    );

    cap_tmr_chan #(
      .CNT_W (CNT_W)
    ) chan_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_n),
      .edge_i    (edge_w[ch]),
      .en_i      (en_w[ch]),
      .cnt_i     (cnt_w),
      .stat_rd_i (stat_rd),
      .hi_rd_i   (hi_rd_w[ch]),
      .lo_rd_i   (lo_rd_w[ch]),
      .lo_acc_i  (lo_acc_w[ch]),
      .cap_o     (cap_w[ch]),
      .flag_o    (flag_w[ch]),
      .lock_o    (lock_w[ch])
    );
  end

  // read data
  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_CTRL) begin
      rdata_o = BYTE_W'(ctrl_q);
    end else if (addr_i == ADDR_STAT) begin
      rdata_o = {{(BYTE_W-NUM_CH){1'b0}}, flag_w};
    end else if (addr_i == ADDR_CNT_HI) begin
      rdata_o = cnt_w[CNT_W-1:BYTE_W];
    end else if (addr_i == ADDR_CNT_LO) begin
      rdata_o = cnt_w[BYTE_W-1:0];
    end
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (addr_i == cap_hi_addr(ch)) begin
        rdata_o = cap_w[ch][CNT_W-1:BYTE_W];
      end else if (addr_i == cap_lo_addr(ch)) begin
        rdata_o = cap_w[ch][BYTE_W-1:0];
      end
    end
  end

  // shared interrupt
  assign irq_o = ctrl_q.ien & ~ctrl_q.gmask & (|flag_w);

endmodule

// File: rtl/cap_timer_chk.sv
module cap_timer_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic                 clk_i,
  input logic                 rst_n,
  input logic [1:0]           tick_sel,
  input logic                 ext_tick_i,
  input logic [CNT_W-1:0]     cnt,
  input logic [1:0]           flag,
  input logic [1:0]           lock,
  input logic [1:0]           lo_rd,
  input logic [1:0]           lo_acc,
  input logic [CNT_W-1:0]     cap0,
  input logic [CNT_W-1:0]     cap1,
  input logic                 ien,
  input logic                 gmask,
  input logic                 ch0_off,
  input logic                 irq_o
);

  // R2
  ext_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (tick_sel == 2'b11 && !ext_tick_i) |=> $stable(cnt));

  // R4
  cap0_value_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(flag[0]) |-> cap0 == $past(cnt));

  // R4
  cap1_value_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(flag[1]) |-> cap1 == $past(cnt));

  // R5
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (gmask || !ien) |-> !irq_o);

  // R6
  flag0_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    $fell(flag[0]) |-> $past(lo_acc[0]));

  // R6
  flag1_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    $fell(flag[1]) |-> $past(lo_acc[1]));

  // R7
  lock0_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (lock[0] && !lo_rd[0]) |=> ($stable(cap0) && !$rose(flag[0])));

  // R7
  lock1_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (lock[1] && !lo_rd[1]) |=> ($stable(cap1) && !$rose(flag[1])));

  // R8
  pulse_off_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (ch0_off && !flag[0]) |=> (!flag[0] && $stable(cap0)));

endmodule

bind cap_timer cap_timer_chk #(
  .CNT_W (CNT_W)
) chk_i (
  .clk_i      (clk_i),
  .rst_n      (rst_n),
  .tick_sel   (ctrl_q.tick_sel),
  .ext_tick_i (ext_tick_i),
  .cnt        (cnt_w),
  .flag       (flag_w),
  .lock       (lock_w),
  .lo_rd      (lo_rd_w),
  .lo_acc     (lo_acc_w),
  .cap0       (cap_w[0]),
  .cap1       (cap_w[1]),
  .ien        (ctrl_q.ien),
  .gmask      (ctrl_q.gmask),
  .ch0_off    (~en_w[0]),
  .irq_o      (irq_o)
);

// File: tb/cap_timer_tb_top.sv
`timescale 1ns/1ps
module cap_timer_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] addr;
  logic       rd, wr;
  logic [7:0] wdata, rdata;
  logic [1:0] pins;
  logic       ext_tick;
  logic       irq;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  cap_timer dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .addr_i     (addr),
    .rd_i       (rd),
    .wr_i       (wr),
    .wdata_i    (wdata),
    .rdata_o    (rdata),
    .cap_pin_i  (pins),
    .ext_tick_i (ext_tick),
    .irq_o      (irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    @(posedge clk);
    #1 rd = 1'b0;
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk);
    #1 wr = 1'b0;
  endtask

  // high then low; for capture registers this also takes and drops the lock
  task automatic rd16(input logic [2:0] a_hi, output logic [15:0] v);
    logic [7:0] h, l;
    bus_rd(a_hi, h);
    bus_rd(a_hi + 3'd1, l);
    v = {h, l};
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk); ext_tick = 1'b1;
      repeat (n) @(negedge clk);
      ext_tick = 1'b0;
    end
  endtask

  task automatic set_pin(input int ch, input logic v);
    @(negedge clk); pins[ch] = v;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [7:0] ctrl_byte(input logic [1:0] sel, input logic ien,
                                           input logic mask, input logic [1:0] rise,
                                           input logic pwm, input logic op);
    return {op, pwm, sel, mask, ien, rise};
  endfunction

  function automatic int cnt_diff(input logic [7:0] a, input logic [7:0] b);
    return int'(8'(b - a));
  endfunction

  task automatic clear_flag(input int ch);
    logic [7:0] d;
    bus_rd(3'd1, d);
    bus_rd(3'(3 + 2 * ch), d);
  endtask

  // produce an active edge of polarity pol on ch; first park the pin at ~pol
  task automatic fire(input int ch, input logic pol);
    if (pins[ch] == pol) set_pin(ch, ~pol);
    set_pin(ch, pol);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [7:0]  d, d0, d1, base;
    logic [15:0] v, c, cap_old;
    int          ch;
    logic        pol;

    void'($urandom(32'd4711));
    rst_n = 1'b0; addr = '0; rd = 1'b0; wr = 1'b0; wdata = '0;
    pins = 2'b00; ext_tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    bus_rd(3'd0, d); check("R1 ctrl", d, 8'h08);
    bus_rd(3'd1, d); check("R1 status", d, 8'h00);
    rd16(3'd2, v);   check("R1 cap1", v, 16'h0);
    rd16(3'd4, v);   check("R1 cap2", v, 16'h0);
    check("R1 irq", irq, 0);

    // R2 tick selection: 40 clocks between samples
    bus_wr(3'd0, ctrl_byte(2'b00, 0, 1, 2'b00, 0, 0));
    bus_rd(3'd7, d0); repeat (39) @(negedge clk); bus_rd(3'd7, d1);
    check("R2 div4", cnt_diff(d0, d1), 10);
    bus_wr(3'd0, ctrl_byte(2'b01, 0, 1, 2'b00, 0, 0));
    bus_rd(3'd7, d0); repeat (39) @(negedge clk); bus_rd(3'd7, d1);
    check("R2 div2", cnt_diff(d0, d1), 20);
    bus_wr(3'd0, ctrl_byte(2'b10, 0, 1, 2'b00, 0, 0));
    bus_rd(3'd7, d0); repeat (39) @(negedge clk); bus_rd(3'd7, d1);
    check("R2 div8", cnt_diff(d0, d1), 5);
    bus_wr(3'd0, ctrl_byte(2'b11, 0, 1, 2'b00, 0, 0));
    bus_rd(3'd7, d0); repeat (39) @(negedge clk); bus_rd(3'd7, d1);
    check("R2 ext idle", cnt_diff(d0, d1), 0);
    bus_rd(3'd7, d0); ticks(37); bus_rd(3'd7, d1);
    check("R2 ext ticks", cnt_diff(d0, d1), 37);

    // R9 latency, seen on irq (ien on, mask off, ch1 rising)
    bus_wr(3'd0, ctrl_byte(2'b11, 1, 0, 2'b01, 0, 0));
    @(negedge clk); pins[0] = 1'b1;
    @(negedge clk); check("R9 after edge k", irq, 0);
    @(negedge clk); check("R9 after edge k+1", irq, 0);
    @(negedge clk); check("R9 after edge k+2", irq, 1);
    clear_flag(0);
    @(negedge clk); check("R6 cleared irq", irq, 0);

    // R3 wrong edge ignored; R5 gating and pending
    bus_wr(3'd0, ctrl_byte(2'b11, 0, 0, 2'b01, 0, 0));
    set_pin(0, 1'b0);
    bus_rd(3'd1, d); check("R3 falling ignored", d, 8'h00);
    set_pin(0, 1'b1);
    check("R5 ien off", irq, 0);
    bus_wr(3'd0, ctrl_byte(2'b11, 1, 1, 2'b01, 0, 0));
    @(negedge clk); check("R5 masked", irq, 0);
    bus_wr(3'd0, ctrl_byte(2'b11, 1, 0, 2'b01, 0, 0));
    @(negedge clk); check("R5 pending raised", irq, 1);
    // R6 low access without status read leaves flag
    bus_rd(3'd3, d);
    @(negedge clk); check("R6 low only keeps flag", irq, 1);
    bus_rd(3'd1, d); check("R6 status before clear", d, 8'h01);
    bus_wr(3'd3, 8'h5A);
    @(negedge clk); check("R6 write clears", irq, 0);
    bus_rd(3'd1, d); check("R6 status after clear", d, 8'h00);

    // R3 R4 random captures
    for (int it = 0; it < 24; it++) begin
      ch  = int'($urandom_range(1, 0));
      pol = 1'($urandom_range(1, 0));
      base = ctrl_byte(2'b11, 0, 1, 2'b00, 0, 0);
      base[ch] = pol;
      bus_wr(3'd0, base);
      if (pins[ch] == pol) begin
        set_pin(ch, ~pol);
        bus_rd(3'd1, d); check("R3 opposite edge ignored", d, 8'h00);
      end
      ticks(int'($urandom_range(300, 0)));
      rd16(3'd6, c);
      set_pin(ch, pol);
      bus_rd(3'd1, d); check("R4 flag set", d, 8'(1 << ch));
      rd16(3'(2 + 2 * ch), v); check("R4 captured value", v, c);
      clear_flag(ch);
      bus_rd(3'd1, d); check("R6 flag cleared", d, 8'h00);
    end

    // R7 high-byte lock
    bus_wr(3'd0, ctrl_byte(2'b11, 0, 1, 2'b11, 0, 0));
    ticks(11); rd16(3'd6, c);
    fire(0, 1'b1);
    rd16(3'd2, cap_old); check("R4 ch1 capture", cap_old, c);
    clear_flag(0);
    bus_rd(3'd2, d0);
    ticks(9);
    fire(0, 1'b1);
    bus_rd(3'd1, d); check("R7 flag blocked", d, 8'h00);
    bus_rd(3'd3, d1); check("R7 coherent value", {d0, d1}, cap_old);
    repeat (4) @(negedge clk);
    bus_rd(3'd1, d); check("R7 blocked edge discarded", d, 8'h00);
    rd16(3'd6, c);
    fire(0, 1'b1);
    rd16(3'd2, v); check("R7 capture after unlock", v, c);
    clear_flag(0);

    // R8 pulse modes block channel 1 only
    bus_wr(3'd0, ctrl_byte(2'b11, 0, 1, 2'b11, 1, 0));
    ticks(5);
    fire(0, 1'b1);
    bus_rd(3'd1, d); check("R8 pwm ch1 ignored", d, 8'h00);
    rd16(3'd2, v); check("R8 pwm ch1 held", v, c);
    bus_wr(3'd0, ctrl_byte(2'b11, 0, 1, 2'b11, 0, 1));
    fire(0, 1'b1);
    bus_rd(3'd1, d); check("R8 one-pulse ch1 ignored", d, 8'h00);
    rd16(3'd6, c);
    fire(1, 1'b1);
    bus_rd(3'd1, d); check("R8 ch2 still works", d, 8'h02);
    rd16(3'd4, v); check("R8 ch2 value", v, c);

    // R6 capture and clearing access on the same edge (ch2 flag armed)
    bus_wr(3'd0, ctrl_byte(2'b11, 0, 1, 2'b11, 0, 0));
    bus_rd(3'd1, d);                  // arms clear for ch2
    ticks(23); rd16(3'd6, c);
    if (pins[1]) set_pin(1, 1'b0);    // falling edge: ignored, arm kept
    @(negedge clk); pins[1] = 1'b1;   // before edge k
    @(negedge clk);                   // after edge k
    @(negedge clk); addr = 3'd5; rd = 1'b1; // spans edge k+2
    @(negedge clk); rd = 1'b0;
    bus_rd(3'd1, d); check("R6 same-edge capture keeps flag", d, 8'h02);
    rd16(3'd4, v); check("R6 same-edge value", v, c);
    bus_rd(3'd1, d); check("R6 final status", d, 8'h00);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule